// File: doc/BRIEF.md
# Dual-Mode Auto-Reload Timer with Capture

This peripheral counts prescaled clock ticks. It runs either as one 16-bit counter or as two independent 8-bit counters, and each counter reloads itself from a reload register when it wraps. Wrap events latch into two sticky flags, one for the low byte and one for the high byte. Software clears a flag by writing a zero to it. An optional capture mode watches a slow reference clock. On each falling edge of that clock, the live 16-bit count is copied into the reload registers. This lets software measure the reference period in timer ticks.

The count source is the system clock divided by 12, or an external clock divided by 8. The external clock is first synchronized into the system clock domain. Software reaches the block through a plain, single-cycle register port. Writes take effect at the next clock edge, and reads are combinational. The port has no back-pressure: every access completes in the cycle it is presented. The block also has one level interrupt request output, which is qualified by an external enable input.

Top module: `dualmode_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, the counter does not move, and `irq` is low.
- R2: The register map is: address 0 control, 1 count low byte, 2 count high byte, 3 reload low byte, 4 reload high byte. The control bits are: 7 high wrap flag, 6 low wrap flag, 5 low-wrap interrupt enable, 4 capture enable, 3 split mode, 2 run, 0 clock select. Control bit 1 always reads 0, and writes to it are ignored.
- R3: In 16-bit mode with run set, each tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets the high flag. With run clear, the count holds.
- R4: In split mode, the high byte is a separate 8-bit counter. A tick at 0xFF loads the reload high byte and sets the high flag. The low byte wraps by loading the reload low byte.
- R5: The low flag is set on every tick that wraps the low byte past 0xFF, in both modes.
- R6: Hardware never clears either flag. A flag clears only on a control write with a 0 in its bit. A wrap in the same cycle as such a write leaves the flag set.
- R7: In split mode, run gates only the high byte. The low byte counts on every tick even with run clear.
- R8: With capture enable set, each falling edge of `ref_clk` copies the current 16-bit count into the reload registers. The edge is seen after a two-flop synchronizer and takes effect three clock edges later. With capture enable clear, the edge has no effect.
- R9: With clock select 0, a tick occurs every 12 system clocks from reset. With clock select 1, a tick occurs on every 8th synchronized rising edge of `ext_clk`.
- R10: `irq` = `int_en` AND (high flag OR (low flag AND low-wrap interrupt enable) OR a capture event). A capture event asserts `irq` for one cycle, in the cycle after the reload registers update.
- R11: A software write to a count or reload byte takes effect at the next edge. It overrides a same-cycle tick update of that byte or a same-cycle capture into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_clk | input | 1 | External clock, asynchronous |
| ref_clk | input | 1 | Slow reference clock for capture, asynchronous |
| int_en | input | 1 | Timer interrupt enable from the interrupt controller |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or count shows at the count registers within one tick, which is at most 12 cycles on the system source or about 48 on the external source. A bad wrap shows as a wrong reload value and a flag that rises on the wrong cycle. Flag errors reach `irq` in the same cycle as the flag. A capture error shows in the reload registers one cycle after the synchronized falling edge, together with a one-cycle `irq` pulse. The bench rotates the read address every cycle and compares the read data and `irq` against a behavioural model on every clock. A divergence is therefore reported within about five cycles of the internal error.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLDL = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLDH = 3'd4;

  // control bit positions
  localparam int B_HF   = 7;
  localparam int B_LF   = 6;
  localparam int B_LIE  = 5;
  localparam int B_CAP  = 4;
  localparam int B_SPL  = 3;
  localparam int B_RUN  = 2;
  localparam int B_XSEL = 0;
endpackage

// File: rtl/tmr_sync_edge.sv
// Two-flop synchronizer plus one history flop; emits a one-cycle pulse
// on the selected edge of the synchronized input.
module tmr_sync_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic [2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[1:0], async_in};
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = ~sr[1] & sr[2];
    end else begin : g_rise
      assign pulse = sr[1] & ~sr[2];
    end
  endgenerate
endmodule

// File: rtl/tmr_prescale.sv
// Divides a stream of step pulses by DIV; tick is high on the DIV-th step.
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = step & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
// Counter datapath: one 16-bit reload counter or two 8-bit reload counters.
module tmr_count_core #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          split,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] rl_lo,
  input  logic [BW-1:0] rl_hi,
  output logic [BW-1:0] cnt_lo,
  output logic [BW-1:0] cnt_hi,
  output logic          wrap_lo,
  output logic          wrap_hi
);
  localparam logic [BW-1:0] ONES = '1;

  logic lo_full, hi_full, step_lo, step_hi;

  assign lo_full = (cnt_lo == ONES);
  assign hi_full = (cnt_hi == ONES);
  // split: low byte free-running, high gated by run
  // joined: both gated by run, high advances on low carry
  assign step_lo = tick & (split | run);
  assign step_hi = tick & run & (split | lo_full);
  assign wrap_lo = step_lo & lo_full;
  assign wrap_hi = step_hi & hi_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
    end else if (wr_lo) begin
      cnt_lo <= wdata;
    end else if (step_lo) begin
      if (lo_full) cnt_lo <= (split | wrap_hi) ? rl_lo : '0;
      else         cnt_lo <= cnt_lo + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_hi <= '0;
    end else if (wr_hi) begin
      cnt_hi <= wdata;
    end else if (step_hi) begin
      cnt_hi <= hi_full ? rl_hi : cnt_hi + 1'b1;
    end
  end
endmodule

// File: rtl/dualmode_reload_timer.sv
module dualmode_reload_timer
  import tmr_pkg::*;
#(
  parameter int SYS_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ext_clk,
  input  logic              ref_clk,
  input  logic              int_en,
  output logic              irq
);
  logic flag_h, flag_l, lie, cap_en, mode_split, run_en, xsel;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi, rl_lo, rl_hi;
  logic ext_rise, ref_fall, sys_tick, ext_tick, tick;
  logic wrap_lo, wrap_hi, cap_fire, cap_q;
  logic wr_ctrl, wr_cl, wr_ch, wr_rl, wr_rh;

  assign wr_ctrl = reg_wr & (reg_addr == A_CTRL);
  assign wr_cl   = reg_wr & (reg_addr == A_CNTL);
  assign wr_ch   = reg_wr & (reg_addr == A_CNTH);
  assign wr_rl   = reg_wr & (reg_addr == A_RLDL);
  assign wr_rh   = reg_wr & (reg_addr == A_RLDH);

  tmr_sync_edge #(.FALLING(1'b0)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .pulse(ext_rise));
  tmr_sync_edge #(.FALLING(1'b1)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_clk), .pulse(ref_fall));

  tmr_prescale #(.DIV(SYS_DIV)) u_sys_div (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .tick(sys_tick));
  tmr_prescale #(.DIV(EXT_DIV)) u_ext_div (
    .clk(clk), .rst_n(rst_n), .step(ext_rise), .tick(ext_tick));

  assign tick = xsel ? ext_tick : sys_tick;

  tmr_count_core #(.BW(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_en), .split(mode_split),
    .wr_lo(wr_cl), .wr_hi(wr_ch), .wdata(reg_wdata),
    .rl_lo(rl_lo), .rl_hi(rl_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi));

  // control register; hardware set of a flag beats a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_h <= 1'b0; flag_l <= 1'b0; lie <= 1'b0; cap_en <= 1'b0;
      mode_split <= 1'b0; run_en <= 1'b0; xsel <= 1'b0;
    end else begin
      flag_h <= (wr_ctrl ? reg_wdata[B_HF] : flag_h) | wrap_hi;
      flag_l <= (wr_ctrl ? reg_wdata[B_LF] : flag_l) | wrap_lo;
      if (wr_ctrl) begin
        lie        <= reg_wdata[B_LIE];
        cap_en     <= reg_wdata[B_CAP];
        mode_split <= reg_wdata[B_SPL];
        run_en     <= reg_wdata[B_RUN];
        xsel       <= reg_wdata[B_XSEL];
      end
    end
  end

  // reload registers with capture
  assign cap_fire = cap_en & ref_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_lo <= '0; rl_hi <= '0; cap_q <= 1'b0;
    end else begin
      cap_q <= cap_fire;
      if (wr_rl)         rl_lo <= reg_wdata;
      else if (cap_fire) rl_lo <= cnt_lo;
      if (wr_rh)         rl_hi <= reg_wdata;
      else if (cap_fire) rl_hi <= cnt_hi;
    end
  end

  assign irq = int_en & (flag_h | (flag_l & lie) | cap_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_HF]   = flag_h;
        reg_rdata[B_LF]   = flag_l;
        reg_rdata[B_LIE]  = lie;
        reg_rdata[B_CAP]  = cap_en;
        reg_rdata[B_SPL]  = mode_split;
        reg_rdata[B_RUN]  = run_en;
        reg_rdata[B_XSEL] = xsel;
      end
      A_CNTL:  reg_rdata = cnt_lo;
      A_CNTH:  reg_rdata = cnt_hi;
      A_RLDL:  reg_rdata = rl_lo;
      A_RLDH:  reg_rdata = rl_hi;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              int_en,
  input logic              irq,
  input logic              flag_h,
  input logic              flag_l,
  input logic              split,
  input logic              run,
  input logic              tick,
  input logic              sys_tick,
  input logic              cap_fire,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] rl_lo,
  input logic [BYTE_W-1:0] rl_hi
);
  logic clr_h, clr_l, wr_cnt, wr_cl, wr_rld;
  assign clr_h  = reg_wr && reg_addr == A_CTRL && !reg_wdata[B_HF];
  assign clr_l  = reg_wr && reg_addr == A_CTRL && !reg_wdata[B_LF];
  assign wr_cl  = reg_wr && reg_addr == A_CNTL;
  assign wr_cnt = reg_wr && (reg_addr == A_CNTL || reg_addr == A_CNTH);
  assign wr_rld = reg_wr && (reg_addr == A_RLDL || reg_addr == A_RLDH);

  p_unused_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_CTRL |-> reg_rdata[1] == 1'b0);

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !run && !wr_cnt) |=> $stable({cnt_hi, cnt_lo}));

  p_hflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_h && !clr_h) |=> flag_h);

  p_lflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_l && !clr_l) |=> flag_l);

  p_low_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split && tick && !wr_cl && !(cnt_lo == '1 && rl_lo == '1))
      |=> cnt_lo != $past(cnt_lo));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !wr_rld) |=> {rl_hi, rl_lo} == $past({cnt_hi, cnt_lo}));

  p_sys_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);

  p_irq_on_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && flag_h) |-> irq);
endmodule

bind dualmode_reload_timer tmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_en(int_en), .irq(irq),
  .flag_h(flag_h), .flag_l(flag_l), .split(mode_split), .run(run_en),
  .tick(tick), .sys_tick(sys_tick), .cap_fire(cap_fire),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .rl_lo(rl_lo), .rl_hi(rl_hi));

// File: tb/dualmode_reload_timer_tb.sv
`timescale 1ns/1ps
module dualmode_reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ext_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       int_en = 1'b0;
  logic       irq;

  always #10 clk = ~clk;  // 50 MHz

  dualmode_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .ref_clk(ref_clk), .int_en(int_en), .irq(irq));

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  int    rot = 0;

  // behavioural reference state
  int m_lo, m_hi, m_rll, m_rlh, m_p12, m_p8;
  bit m_hf, m_lf, m_lie, m_cap, m_spl, m_run, m_xs, m_capq;
  bit eh[$];
  bit rh[$];

  function automatic int model_read(input int a);
    case (a)
      0: return (int'(m_hf) << 7) | (int'(m_lf) << 6) | (int'(m_lie) << 5) |
                (int'(m_cap) << 4) | (int'(m_spl) << 3) | (int'(m_run) << 2) |
                int'(m_xs);
      1: return m_lo;
      2: return m_hi;
      3: return m_rll;
      4: return m_rlh;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_rll = 0; m_rlh = 0; m_p12 = 0; m_p8 = 0;
      m_hf = 0; m_lf = 0; m_lie = 0; m_cap = 0; m_spl = 0; m_run = 0;
      m_xs = 0; m_capq = 0;
      eh = '{0, 0, 0}; rh = '{0, 0, 0};
    end else begin
      bit stk, etk, erise, rfall, tk, set_h, set_l, capf;
      int nlo, nhi, nrll, nrlh, full;
      stk = (m_p12 == 11);
      m_p12 = stk ? 0 : m_p12 + 1;
      erise = eh[1] && !eh[2];
      etk = erise && (m_p8 == 7);
      if (erise) m_p8 = etk ? 0 : m_p8 + 1;
      rfall = !rh[1] && rh[2];
      tk = m_xs ? etk : stk;
      nlo = m_lo; nhi = m_hi; set_h = 0; set_l = 0;
      if (m_spl) begin
        if (tk) begin
          if (m_lo == 255) begin nlo = m_rll; set_l = 1; end else nlo = m_lo + 1;
          if (m_run) begin
            if (m_hi == 255) begin nhi = m_rlh; set_h = 1; end else nhi = m_hi + 1;
          end
        end
      end else if (tk && m_run) begin
        full = m_hi * 256 + m_lo;
        if (full == 65535) begin
          nlo = m_rll; nhi = m_rlh; set_h = 1; set_l = 1;
        end else begin
          if (m_lo == 255) set_l = 1;
          full = full + 1;
          nlo = full % 256; nhi = full / 256;
        end
      end
      capf = m_cap && rfall;
      nrll = capf ? m_lo : m_rll;
      nrlh = capf ? m_hi : m_rlh;
      m_capq = capf;
      if (reg_wr) begin
        case (int'(reg_addr))
          0: begin
            m_hf = reg_wdata[7]; m_lf = reg_wdata[6]; m_lie = reg_wdata[5];
            m_cap = reg_wdata[4]; m_spl = reg_wdata[3]; m_run = reg_wdata[2];
            m_xs = reg_wdata[0];
          end
          1: nlo = int'(reg_wdata);
          2: nhi = int'(reg_wdata);
          3: nrll = int'(reg_wdata);
          4: nrlh = int'(reg_wdata);
          default: ;
        endcase
      end
      m_hf = m_hf | set_h;
      m_lf = m_lf | set_l;
      m_lo = nlo; m_hi = nhi; m_rll = nrll; m_rlh = nrlh;
      eh.push_front(ext_clk); void'(eh.pop_back());
      rh.push_front(ref_clk); void'(rh.pop_back());
    end
  end

  // compare away from the active edge, every cycle
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      int exp_rd;
      bit exp_irq;
      exp_rd = model_read(int'(reg_addr));
      exp_irq = int_en && (m_hf || (m_lf && m_lie) || m_capq);
      n_checks++;
      if (int'(reg_rdata) != exp_rd) begin
        n_fail++;
        $display("FAIL %s: addr %0d read 0x%02h expected 0x%02h at %0t",
                 cur_req, reg_addr, reg_rdata, exp_rd, $time);
      end
      n_checks++;
      if (irq !== exp_irq) begin
        n_fail++;
        $display("FAIL %s: irq %0b expected %0b at %0t", cur_req, irq, exp_irq, $time);
      end
    end
  end

  // free-running external clock: rising edge every 6 system clocks
  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = 3'(rot % 5);
      rot++;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ref_pulse(input int hi_len, input int lo_len);
    @(negedge clk); ref_clk = 1'b1;
    idle(hi_len);
    @(negedge clk); ref_clk = 1'b0;
    idle(lo_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, nothing moves
    cur_req = "R1";
    idle(15);
    // R2: bit 1 of control ignored on write, reads 0
    cur_req = "R2";
    wr(0, 8'h02);
    idle(6);
    // R3 / R9: 16-bit run on divided system clock, wrap and reload
    cur_req = "R3";
    wr(3, 8'h34); wr(4, 8'h12);
    wr(1, 8'hF0); wr(2, 8'hFF);
    wr(0, 8'h04);
    idle(240);
    cur_req = "R9";
    idle(30);
    // R6: flags stay set until written to zero
    cur_req = "R6";
    wr(0, 8'h00);
    idle(10);
    wr(0, 8'hC0);
    idle(10);
    // R10: interrupt combining
    cur_req = "R10";
    int_en = 1'b1;
    idle(5);
    wr(0, 8'h40);
    idle(5);
    wr(0, 8'h60);
    idle(5);
    wr(0, 8'h20);
    idle(5);
    int_en = 1'b0;
    wr(0, 8'h00);
    // R7 / R5: split mode with run clear, low free-running
    cur_req = "R7";
    wr(1, 8'hF8); wr(2, 8'hFC); wr(3, 8'h80); wr(4, 8'h10);
    wr(0, 8'h08);
    idle(150);
    cur_req = "R5";
    wr(0, 8'h28);
    idle(40);
    // R4: split with run, high byte wraps and reloads
    cur_req = "R4";
    wr(0, 8'h0C);
    idle(120);
    wr(0, 8'h00);
    // R9: external clock source in 16-bit mode
    cur_req = "R9";
    wr(1, 8'hFE); wr(2, 8'hFF); wr(3, 8'h00); wr(4, 8'hA0);
    wr(0, 8'h05);
    idle(220);
    // R8: capture on reference falling edges, irq pulse
    cur_req = "R8";
    int_en = 1'b1;
    wr(0, 8'h14);
    idle(7);
    ref_pulse(9, 40);
    ref_pulse(20, 60);
    ref_pulse(4, 30);
    // R8: capture disabled, edge ignored
    wr(0, 8'h04);
    ref_pulse(5, 30);
    int_en = 1'b0;
    // R11: writes colliding with ticks and captures
    cur_req = "R11";
    wr(0, 8'h04);
    for (int i = 0; i < 26; i++) wr(1, 8'hFF);
    wr(0, 8'h14);
    @(negedge clk); ref_clk = 1'b1;
    idle(5);
    @(negedge clk); ref_clk = 1'b0;
    for (int i = 0; i < 6; i++) wr(3, 8'h5A);
    idle(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL %s: watchdog expired, actual running expected finished", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule